// File: doc/BRIEF.md
# Conditional and Counting Branch Unit

This block is the branch-resolution stage of a 32-bit processor pipeline. Each cycle it may accept one branch operation, qualified by a valid strobe, and decide whether control moves to the effective address or falls through to the next word. It supports four operations. Two test a 4-bit mask against the 4-bit condition code: one branches when any selected condition bit is set, the other when none is. The other two step a general register up or down by one and branch on the sign of the new value.

The counting branches write the stepped value back to the register. A taken counting branch can be cancelled by fault flags that the fetch unit raises for the branch target. A protection or nonexistent-address fault and a parity fault each cause a trap request with its own vector. The saved address is that of the branch itself, and the register write-back is suppressed. All results are registered and appear one clock after the strobe.

Top module: `brx_unit`

## Requirements
- R1: Opcode 0 (conditions-set) is taken when the bitwise AND of mask and condition code is nonzero, so a zero mask never branches. It never writes the register.
- R2: Opcode 1 (conditions-reset) is taken when that AND is zero, so a zero mask always branches. It never writes the register.
- R3: A taken, non-trapping branch sets the next address to the effective address. A branch that is not taken sets it to the current address plus one, modulo 2^17.
- R4: Opcode 2 (increment) writes the register value plus one, modulo 2^32. It is taken when bit 31 (the sign) of the result is 1.
- R5: Opcode 3 (decrement) writes the register value minus one, modulo 2^32. It is taken only when the result has bit 31 clear and is nonzero.
- R6: A taken counting branch with the protection fault flag set requests a trap with vector 0x40. The saved address equals the current address, the next address equals the current address, and the register write is suppressed.
- R7: A taken counting branch with only the parity fault flag set traps the same way with vector 0x4C. When both flags are set, vector 0x40 wins.
- R8: Fault flags have no effect on conditional opcodes or on counting branches that are not taken.
- R9: Results appear on the clock edge after a cycle with the valid strobe high. In a cycle without the strobe, the update, write-enable and trap outputs go low on the next edge and the next address holds.
- R10: Synchronous active-high reset clears update, write-enable, trap and next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation code (0 set, 1 reset, 2 increment, 3 decrement) |
| mask_i | input | 4 | Condition mask field |
| cc_i | input | 4 | Current condition code |
| reg_i | input | 32 | Register contents before the operation |
| ea_i | input | 17 | Effective (target) word address |
| ia_i | input | 17 | Address of this branch |
| prot_flt_i | input | 1 | Target protected or nonexistent |
| par_flt_i | input | 1 | Parity error fetching target |
| upd_o | output | 1 | Registered result valid |
| next_ia_o | output | 17 | Next instruction address |
| wb_en_o | output | 1 | Register write enable |
| wb_data_o | output | 32 | Register write value |
| trap_o | output | 1 | Trap request |
| trap_vec_o | output | 8 | Trap vector |
| trap_addr_o | output | 17 | Saved address for the trap |

## Verification
The assertions assume that the opcode, mask, condition code, register value and addresses are known whenever the strobe is high. They also assume that the fault flags are plain levels sampled in the same cycle as the strobe. The stimulus drives every input to a defined value on the falling edge, holds it through the next rising edge, and lowers the strobe between operations. This way, idle cycles also exercise the hold behaviour. The conditional opcodes are swept over every mask and condition code pair. The counting opcodes are crossed over sign-boundary register values and all four fault-flag combinations.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    OP_CC_SET = 2'd0,
    OP_CC_CLR = 2'd1,
    OP_CNT_INC = 2'd2,
    OP_CNT_DEC = 2'd3
  } brx_op_e;
endpackage

// File: rtl/brx_cond_eval.sv
module brx_cond_eval #(
  parameter int MASK_W = 4
) (
  input  logic              want_clear,
  input  logic [MASK_W-1:0] mask,
  input  logic [MASK_W-1:0] cc,
  output logic              taken
);
  logic any_hit;
  always_comb begin
    any_hit = |(mask & cc);
    taken   = want_clear ? !any_hit : any_hit;
  end
endmodule

// File: rtl/brx_count_eval.sv
module brx_count_eval #(
  parameter int DATA_W = 32
) (
  input  logic              step_down,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] result,
  output logic              taken
);
  localparam int SIGN = DATA_W - 1;
  always_comb begin
    result = step_down ? val - DATA_W'(1) : val + DATA_W'(1);
    if (step_down) taken = !result[SIGN] && (|result);
    else           taken = result[SIGN];
  end
endmodule

// File: rtl/brx_fault_sel.sv
module brx_fault_sel #(
  parameter int          VEC_W   = 8,
  parameter logic [VEC_W-1:0] PROT_VEC = 8'h40,
  parameter logic [VEC_W-1:0] PAR_VEC  = 8'h4C
) (
  input  logic             is_count,
  input  logic             taken,
  input  logic             prot_flt,
  input  logic             par_flt,
  output logic             abort,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    abort = is_count && taken && (prot_flt || par_flt);
    vec   = prot_flt ? PROT_VEC : PAR_VEC;
  end
endmodule

// File: rtl/brx_unit.sv
module brx_unit #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [MASK_W-1:0] cc_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [ADDR_W-1:0] ia_i,
  input  logic              prot_flt_i,
  input  logic              par_flt_i,
  output logic              upd_o,
  output logic [ADDR_W-1:0] next_ia_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              trap_o,
  output logic [VEC_W-1:0]  trap_vec_o,
  output logic [ADDR_W-1:0] trap_addr_o
);
  import brx_pkg::*;

  brx_op_e           op;
  logic              is_count;
  logic              cond_taken;
  logic              cnt_taken;
  logic              taken;
  logic              abort;
  logic [DATA_W-1:0] cnt_res;
  logic [VEC_W-1:0]  vec;
  logic [ADDR_W-1:0] ia_seq;

  always_comb begin
    op       = brx_op_e'(op_i);
    is_count = (op == OP_CNT_INC) || (op == OP_CNT_DEC);
    ia_seq   = ia_i + ADDR_W'(1);
  end

  brx_cond_eval #(.MASK_W(MASK_W)) u_cond (
    .want_clear (op == OP_CC_CLR),
    .mask       (mask_i),
    .cc         (cc_i),
    .taken      (cond_taken)
  );

  brx_count_eval #(.DATA_W(DATA_W)) u_count (
    .step_down (op == OP_CNT_DEC),
    .val       (reg_i),
    .result    (cnt_res),
    .taken     (cnt_taken)
  );

  assign taken = is_count ? cnt_taken : cond_taken;

  brx_fault_sel #(.VEC_W(VEC_W)) u_fault (
    .is_count (is_count),
    .taken    (taken),
    .prot_flt (prot_flt_i),
    .par_flt  (par_flt_i),
    .abort    (abort),
    .vec      (vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_o       <= 1'b0;
      next_ia_o   <= '0;
      wb_en_o     <= 1'b0;
      wb_data_o   <= '0;
      trap_o      <= 1'b0;
      trap_vec_o  <= '0;
      trap_addr_o <= '0;
    end else begin
      upd_o   <= valid_i;
      wb_en_o <= 1'b0;
      trap_o  <= 1'b0;
      if (valid_i) begin
        wb_data_o   <= cnt_res;
        wb_en_o     <= is_count && !abort;
        trap_o      <= abort;
        trap_vec_o  <= vec;
        trap_addr_o <= ia_i;
        if (abort)      next_ia_o <= ia_i;
        else if (taken) next_ia_o <= ea_i;
        else            next_ia_o <= ia_seq;
      end
    end
  end
endmodule

// File: rtl/brx_chk.sv
module brx_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [MASK_W-1:0] mask_i,
  input logic [MASK_W-1:0] cc_i,
  input logic [DATA_W-1:0] reg_i,
  input logic [ADDR_W-1:0] ea_i,
  input logic              upd_o,
  input logic [ADDR_W-1:0] next_ia_o,
  input logic              wb_en_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic              trap_o,
  input logic [VEC_W-1:0]  trap_vec_o
);
  p_set_taken_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 2'd0 && (mask_i & cc_i) != '0) |=> (next_ia_o == $past(ea_i) && !wb_en_o));

  p_clr_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 2'd1 && (mask_i & cc_i) == '0) |=> (next_ia_o == $past(ea_i) && !wb_en_o));

  p_inc_data_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 2'd2) |=> (wb_data_o == $past(reg_i) + DATA_W'(1)));

  p_dec_data_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 2'd3) |=> (wb_data_o == $past(reg_i) - DATA_W'(1)));

  p_trap_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (!wb_en_o && upd_o));

  p_trap_vec_r7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (trap_vec_o == VEC_W'(8'h40) || trap_vec_o == VEC_W'(8'h4C)));

  p_cond_no_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !op_i[1]) |=> !trap_o);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!upd_o && !wb_en_o && !trap_o && $stable(next_ia_o)));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!upd_o && !wb_en_o && !trap_o && next_ia_o == '0));
endmodule

bind brx_unit brx_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .mask_i(mask_i),
  .cc_i(cc_i), .reg_i(reg_i), .ea_i(ea_i), .upd_o(upd_o), .next_ia_o(next_ia_o),
  .wb_en_o(wb_en_o), .wb_data_o(wb_data_o), .trap_o(trap_o), .trap_vec_o(trap_vec_o)
);

// File: tb/sim_brx_unit.sv
`timescale 1ns/1ps
module sim_brx_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  op_i;
  logic [3:0]  mask_i, cc_i;
  logic [31:0] reg_i;
  logic [16:0] ea_i, ia_i;
  logic        prot_flt_i, par_flt_i;
  logic        upd_o, wb_en_o, trap_o;
  logic [16:0] next_ia_o, trap_addr_o;
  logic [31:0] wb_data_o;
  logic [7:0]  trap_vec_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  brx_unit u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .mask_i(mask_i),
    .cc_i(cc_i), .reg_i(reg_i), .ea_i(ea_i), .ia_i(ia_i),
    .prot_flt_i(prot_flt_i), .par_flt_i(par_flt_i), .upd_o(upd_o),
    .next_ia_o(next_ia_o), .wb_en_o(wb_en_o), .wb_data_o(wb_data_o),
    .trap_o(trap_o), .trap_vec_o(trap_vec_o), .trap_addr_o(trap_addr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [3:0] m, input logic [3:0] c,
                        input logic [31:0] r, input logic [16:0] ea, input logic [16:0] ia,
                        input logic pf, input logic qf);
    logic [31:0] res;
    logic        tk, cnt, flt;
    logic [16:0] nx;
    string       tg;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; mask_i = m; cc_i = c; reg_i = r;
    ea_i = ea; ia_i = ia; prot_flt_i = pf; par_flt_i = qf;
    @(negedge clk);
    valid_i = 1'b0;
    cnt = op[1];
    res = (op == 2'd3) ? r - 32'd1 : r + 32'd1;
    case (op)
      2'd0: begin tk = (m & c) != 4'd0; tg = "R1"; end
      2'd1: begin tk = (m & c) == 4'd0; tg = "R2"; end
      2'd2: begin tk = res[31]; tg = "R4"; end
      default: begin tk = !res[31] && res != 32'd0; tg = "R5"; end
    endcase
    flt = cnt && tk && (pf || qf);
    if (!cnt && (pf || qf)) tg = {tg, "/R8"};
    nx = flt ? ia : (tk ? ea : ia + 17'd1);
    check({tg, " R3 next"}, 32'(next_ia_o), 32'(nx));
    check({tg, " R9 upd"}, 32'(upd_o), 32'd1);
    check({tg, " wb_en"}, 32'(wb_en_o), 32'(cnt && !flt));
    check({tg, " R8 trap"}, 32'(trap_o), 32'(flt));
    if (cnt) check({tg, " wb_data"}, wb_data_o, res);
    if (flt) begin
      check(pf ? "R6 vec" : "R7 vec", 32'(trap_vec_o), pf ? 32'h40 : 32'h4C);
      check("R6 saved addr", 32'(trap_addr_o), 32'(ia));
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [10];
    logic [16:0] held;
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
             32'h8000_0001, 32'h2, 32'hFFFF_FFFE, 32'h1234_5678, 32'hC000_0000};
    rst = 1'b1; valid_i = 1'b0; op_i = 2'd0; mask_i = 4'd0; cc_i = 4'd0;
    reg_i = 32'd0; ea_i = 17'd0; ia_i = 17'd0; prot_flt_i = 1'b0; par_flt_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 upd", 32'(upd_o), 32'd0);
    check("R10 trap", 32'(trap_o), 32'd0);
    check("R10 wb_en", 32'(wb_en_o), 32'd0);
    check("R10 next", 32'(next_ia_o), 32'd0);
    rst = 1'b0;

    for (int op = 0; op < 2; op++)
      for (int m = 0; m < 16; m++)
        for (int c = 0; c < 16; c++)
          run_op(2'(op), 4'(m), 4'(c), 32'(m * 16 + c), 17'(1000 + m * 16 + c),
                 17'(c * 37 + m), c[0], c[1]);

    run_op(2'd1, 4'd0, 4'd0, 32'd0, 17'h00ABC, 17'h1FFFF, 1'b0, 1'b0);
    run_op(2'd0, 4'd0, 4'hF, 32'd0, 17'h00ABC, 17'h1FFFF, 1'b0, 1'b0);

    for (int op = 2; op < 4; op++)
      for (int v = 0; v < 10; v++)
        for (int f = 0; f < 4; f++)
          run_op(2'(op), 4'(v), 4'd0, vals[v], 17'(20000 + v * 4 + f),
                 17'(500 + v), f[0], f[1]);

    held = next_ia_o;
    @(negedge clk);
    check("R9 idle upd", 32'(upd_o), 32'd0);
    check("R9 idle hold", 32'(next_ia_o), 32'(held));

    run_op(2'd2, 4'd1, 4'd0, 32'h7FFF_FFFF, 17'h1_0000, 17'h00010, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b1; op_i = 2'd2; reg_i = 32'hFFFF_FFFE; prot_flt_i = 1'b1;
    @(negedge clk);
    check("R10 trap in reset", 32'(trap_o), 32'd0);
    rst = 1'b0; valid_i = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule